// File: doc/BRIEF.md
# Performance Cycle Counter with Debug Access

This block is the cycle counter of a processor performance monitor. It holds a 64-bit count that advances on every clock, or once per 64 clocks when a divide select is set. A separate enable input, produced elsewhere from mode and security filtering, decides cycle by cycle whether counting is allowed. A single-cycle clear pulse zeroes the count and the divide prescaler.

An external debugger reaches the count through a 32-bit word port. The low word sits at byte offset 0x0F8 and the high word at 0x0FC. Five condition inputs decide whether an access is granted: core power, double lock, OS lock, external permission and software lock. A granted access is read-write or read-only, and anything else returns an error. The count is reset only by the core reset. The debug-side reset clears only the response registers of the port.

Top module: `cyc_perf_counter`

## Requirements
- R1: While `rst_n` is low, `count_o`, `ovf_o`, `dbg_ack`, `dbg_resp` and `dbg_rdata` are all zero, and the prescaler is cleared.
- R2: With `cnt_en`=1 and `div64_sel`=0, `count_o` rises by exactly one per clock.
- R3: With `div64_sel`=1, a 6-bit prescaler advances on each enabled clock. `count_o` rises by one only on the enabled clock where the prescaler reads 63, so the first step after a clear comes on the 64th enabled clock.
- R4: With `cnt_en`=0, both `count_o` and the prescaler hold their values.
- R5: A `clr_pulse` makes `count_o` and the prescaler zero on the next clock, and it overrides an increment in the same cycle. A permitted write in that cycle still lands in its word.
- R6: An access is granted when `core_pwr`=1, `dbl_lock`=0, `os_lock`=0, `ext_allow`=1 and the offset is 0x0F8 or 0x0FC. `dbg_resp` is then 2'b00 (read-write) when `sw_lock`=0, or 2'b01 (read-only) when `sw_lock`=1. Any other access returns 2'b11 (error).
- R7: `dbg_ack` follows `dbg_req` by one clock. On a granted access, `dbg_rdata` carries bits [31:0] for offset 0x0F8 or bits [63:32] for offset 0x0FC, taken from the count in the request cycle. On an error, or when no access is made, `dbg_rdata` and `dbg_resp` are zero.
- R8: A granted read-write access with `dbg_wr`=1 replaces only the addressed 32-bit word on the next clock. It takes priority over an increment for that word, while the other word keeps its normal next value.
- R9: A write that is answered read-only or error changes nothing; the count evolves as if no write were made.
- R10: The count wraps from all ones to zero. `ovf_o` is high for exactly the one cycle in which `count_o` first shows the wrapped zero. There is no overflow flag when a clear or a permitted write happens in the wrapping cycle.
- R11: While `dbg_rst_n` is low, `dbg_ack`, `dbg_resp` and `dbg_rdata` are zero, and the count and prescaler keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Core reset, asynchronous, active low |
| dbg_rst_n | input | 1 | Debug-side reset for the access port, active low |
| cnt_en | input | 1 | Filter enable for counting this cycle |
| div64_sel | input | 1 | 1: count once per 64 enabled clocks |
| clr_pulse | input | 1 | Zero the count and the prescaler |
| core_pwr | input | 1 | Core is powered |
| dbl_lock | input | 1 | Double lock is set |
| os_lock | input | 1 | OS lock is set |
| ext_allow | input | 1 | External monitor access is permitted |
| sw_lock | input | 1 | Software lock set, making access read-only |
| dbg_req | input | 1 | Access request, one cycle |
| dbg_wr | input | 1 | Request is a write |
| dbg_addr | input | 12 | Byte offset of the access |
| dbg_wdata | input | 32 | Write data |
| dbg_ack | output | 1 | Response valid |
| dbg_resp | output | 2 | 00 read-write, 01 read-only, 11 error |
| dbg_rdata | output | 32 | Read data |
| count_o | output | 64 | Current count |
| ovf_o | output | 1 | Wrap flag, one cycle |

## Verification
The bench aims at the cycles where sources of change meet:
- A write to the low word while that word carries into the high word. A design that applied the write before the increment would leave the high word one short, or change the low word.
- A clear that lands mid-way through a prescaler period. If the prescaler were not cleared, the next step would come early.
- Each condition input failing on its own. A decoder that skipped one of them would grant access, or let a locked write through.
- The wrap, with and without a same-cycle write. A misplaced flag would fire one cycle off, or fire over a write.
- Debug-side reset during counting, which must not disturb the count.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

   typedef enum logic [1:0] {
      RESP_RW  = 2'b00,
      RESP_RO  = 2'b01,
      RESP_ERR = 2'b11
   } dbg_resp_e;

   typedef struct packed {
      logic granted;
      logic writable;
   } perm_t;

   function automatic perm_t judge(input logic pwr, input logic dbl,
                                   input logic osl, input logic allow,
                                   input logic swl, input logic hit);
      perm_t p;
      p.granted  = pwr & ~dbl & ~osl & allow & hit;
      p.writable = p.granted & ~swl;
      return p;
   endfunction

endpackage

// File: rtl/cyc_prescale.sv
module cyc_prescale #(
   parameter int PRE_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic div_sel,
   input  logic clr,
   output logic tick
);
   localparam logic [PRE_W-1:0] TOP = {PRE_W{1'b1}};

   logic [PRE_W-1:0] pre_q;

   // step the main count either every enabled clock or at prescaler top
   assign tick = en & (~div_sel | (pre_q == TOP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (clr)
         pre_q <= '0;
      else if (en && div_sel)
         pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core #(
   parameter int CNT_W = 64,
   parameter int BUS_W = 32,
   localparam int NWORDS = CNT_W / BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              clr,
   input  logic [NWORDS-1:0] word_we,
   input  logic [BUS_W-1:0]  wdata,
   output logic [CNT_W-1:0]  count,
   output logic              ovf
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] nxt;
   logic             wrap;

   always_comb begin
      nxt = count_q + CNT_W'(tick);
      if (clr)
         nxt = '0;
      for (int i = 0; i < NWORDS; i++) begin
         if (word_we[i])
            nxt[i*BUS_W +: BUS_W] = wdata;
      end
   end

   assign wrap = tick & (&count_q) & ~clr & ~(|word_we);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         ovf     <= 1'b0;
      end else begin
         count_q <= nxt;
         ovf     <= wrap;
      end
   end

   assign count = count_q;
endmodule

// File: rtl/cyc_dbg_port.sv
module cyc_dbg_port
   import cyc_pkg::*;
#(
   parameter int CNT_W    = 64,
   parameter int BUS_W    = 32,
   parameter int ADDR_W   = 12,
   parameter int BASE_OFS = 'h0F8,
   localparam int NWORDS  = CNT_W / BUS_W,
   localparam int BYTES   = BUS_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_pwr,
   input  logic              dbl_lock,
   input  logic              os_lock,
   input  logic              ext_allow,
   input  logic              sw_lock,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  count,
   output logic [NWORDS-1:0] word_we,
   output logic              ack,
   output logic [1:0]        resp,
   output logic [BUS_W-1:0]  rdata
);
   logic [NWORDS-1:0] hit;
   logic [BUS_W-1:0]  words [NWORDS];
   logic [BUS_W-1:0]  sel;
   perm_t             perm;

   for (genvar i = 0; i < NWORDS; i++) begin : g_word
      localparam int OFS = BASE_OFS + BYTES * i;
      assign hit[i]   = (addr == OFS[ADDR_W-1:0]);
      assign words[i] = count[i*BUS_W +: BUS_W];
   end

   always_comb begin
      sel = '0;
      for (int i = 0; i < NWORDS; i++) begin
         if (hit[i])
            sel = words[i];
      end
   end

   assign perm    = judge(core_pwr, dbl_lock, os_lock, ext_allow, sw_lock, |hit);
   assign word_we = (req && wr && perm.writable) ? hit : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack   <= 1'b0;
         resp  <= 2'b00;
         rdata <= '0;
      end else begin
         ack <= req;
         if (req && perm.granted) begin
            resp  <= perm.writable ? RESP_RW : RESP_RO;
            rdata <= sel;
         end else if (req) begin
            resp  <= RESP_ERR;
            rdata <= '0;
         end else begin
            resp  <= 2'b00;
            rdata <= '0;
         end
      end
   end
endmodule

// File: rtl/cyc_perf_counter.sv
module cyc_perf_counter #(
   parameter int CNT_W    = 64,
   parameter int BUS_W    = 32,
   parameter int PRE_W    = 6,
   parameter int ADDR_W   = 12,
   parameter int BASE_OFS = 'h0F8,
   localparam int NWORDS  = CNT_W / BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbg_rst_n,
   input  logic              cnt_en,
   input  logic              div64_sel,
   input  logic              clr_pulse,
   input  logic              core_pwr,
   input  logic              dbl_lock,
   input  logic              os_lock,
   input  logic              ext_allow,
   input  logic              sw_lock,
   input  logic              dbg_req,
   input  logic              dbg_wr,
   input  logic [ADDR_W-1:0] dbg_addr,
   input  logic [BUS_W-1:0]  dbg_wdata,
   output logic              dbg_ack,
   output logic [1:0]        dbg_resp,
   output logic [BUS_W-1:0]  dbg_rdata,
   output logic [CNT_W-1:0]  count_o,
   output logic              ovf_o
);
   if (CNT_W % BUS_W != 0) begin : g_bad_split
      $error("count width must be a multiple of the port width");
   end
   if (BUS_W % 8 != 0) begin : g_bad_bus
      $error("port width must be whole bytes");
   end
   if (PRE_W < 1) begin : g_bad_pre
      $error("prescaler needs at least one bit");
   end
   if (BASE_OFS + (BUS_W / 8) * NWORDS > (1 << ADDR_W)) begin : g_bad_ofs
      $error("word offsets do not fit the address width");
   end

   logic              tick;
   logic [NWORDS-1:0] word_we;
   logic              port_rst_n;

   assign port_rst_n = rst_n & dbg_rst_n;

   cyc_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cnt_en),
      .div_sel (div64_sel),
      .clr     (clr_pulse),
      .tick    (tick)
   );

   cyc_count_core #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .clr     (clr_pulse),
      .word_we (word_we),
      .wdata   (dbg_wdata),
      .count   (count_o),
      .ovf     (ovf_o)
   );

   cyc_dbg_port #(
      .CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)
   ) u_port (
      .clk       (clk),
      .rst_n     (port_rst_n),
      .core_pwr  (core_pwr),
      .dbl_lock  (dbl_lock),
      .os_lock   (os_lock),
      .ext_allow (ext_allow),
      .sw_lock   (sw_lock),
      .req       (dbg_req),
      .wr        (dbg_wr),
      .addr      (dbg_addr),
      .count     (count_o),
      .word_we   (word_we),
      .ack       (dbg_ack),
      .resp      (dbg_resp),
      .rdata     (dbg_rdata)
   );
endmodule

// File: rtl/cyc_perf_counter_chk.sv
module cyc_perf_counter_chk #(
   parameter int CNT_W = 64,
   parameter int BUS_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dbg_rst_n,
   input logic             cnt_en,
   input logic             div64_sel,
   input logic             clr_pulse,
   input logic             core_pwr,
   input logic             dbl_lock,
   input logic             os_lock,
   input logic             ext_allow,
   input logic             sw_lock,
   input logic             dbg_req,
   input logic             dbg_wr,
   input logic             dbg_ack,
   input logic [1:0]       dbg_resp,
   input logic [BUS_W-1:0] dbg_rdata,
   input logic [CNT_W-1:0] count_o,
   input logic             ovf_o
);
   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en && !div64_sel && !clr_pulse && !(dbg_req && dbg_wr)
      |=> count_o == CNT_W'($past(count_o) + 1'b1));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en && !clr_pulse && !(dbg_req && dbg_wr) |=> $stable(count_o));

   // R5
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse && !(dbg_req && dbg_wr) |=> count_o == '0);

   // R6
   deny_err_chk: assert property (@(posedge clk) disable iff (!rst_n || !dbg_rst_n)
      dbg_req && (!core_pwr || dbl_lock || os_lock || !ext_allow)
      |=> dbg_resp == 2'b11 && dbg_rdata == '0);

   // R7
   ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !dbg_rst_n)
      dbg_req |=> dbg_ack);

   // R9
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req && dbg_wr && sw_lock && !cnt_en && !clr_pulse |=> $stable(count_o));

   // R10
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> count_o == '0);

   // R11
   port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_rst_n |-> !dbg_ack && dbg_resp == 2'b00);
endmodule

bind cyc_perf_counter cyc_perf_counter_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dbg_rst_n(dbg_rst_n), .cnt_en(cnt_en),
   .div64_sel(div64_sel), .clr_pulse(clr_pulse), .core_pwr(core_pwr),
   .dbl_lock(dbl_lock), .os_lock(os_lock), .ext_allow(ext_allow),
   .sw_lock(sw_lock), .dbg_req(dbg_req), .dbg_wr(dbg_wr), .dbg_ack(dbg_ack),
   .dbg_resp(dbg_resp), .dbg_rdata(dbg_rdata), .count_o(count_o), .ovf_o(ovf_o)
);

// File: tb/sim_cyc_perf_counter.sv
module sim_cyc_perf_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0, dbg_rst_n = 1'b1;
   logic        cnt_en = 1'b0, div64_sel = 1'b0, clr_pulse = 1'b0;
   logic        core_pwr = 1'b1, dbl_lock = 1'b0, os_lock = 1'b0;
   logic        ext_allow = 1'b1, sw_lock = 1'b0;
   logic        dbg_req = 1'b0, dbg_wr = 1'b0;
   logic [11:0] dbg_addr = 12'h0F8;
   logic [31:0] dbg_wdata = '0;
   logic        dbg_ack;
   logic [1:0]  dbg_resp;
   logic [31:0] dbg_rdata;
   logic [63:0] count_o;
   logic        ovf_o;

   int    checks = 0, errors = 0;
   string tag = "R1";
   bit    done = 1'b0;

   // reference state
   logic [63:0] m_cnt = '0;
   int          m_pre = 0;
   logic        m_ovf = 1'b0, m_ack = 1'b0;
   logic [1:0]  m_resp = '0;
   logic [31:0] m_rdata = '0;

   always #10 clk = ~clk;

   cyc_perf_counter u0 (.*);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_pre = 0; m_ovf = 0; m_ack = 0; m_resp = 0; m_rdata = 0;
      end else begin
         bit inc, okc, hlo, hhi, grant, we;
         logic [63:0] nxt;
         inc   = cnt_en && (!div64_sel || m_pre == 63);
         okc   = core_pwr && !dbl_lock && !os_lock && ext_allow;
         hlo   = dbg_addr == 12'h0F8;
         hhi   = dbg_addr == 12'h0FC;
         grant = dbg_req && okc && (hlo || hhi);
         we    = grant && dbg_wr && !sw_lock;
         nxt   = m_cnt + 64'(inc);
         if (clr_pulse) nxt = '0;
         if (we && hlo) nxt[31:0]  = dbg_wdata;
         if (we && hhi) nxt[63:32] = dbg_wdata;
         m_ovf = inc && (m_cnt == '1) && !clr_pulse && !we;
         if (clr_pulse) m_pre = 0;
         else if (cnt_en && div64_sel) m_pre = (m_pre + 1) % 64;
         if (!dbg_rst_n) begin
            m_ack = 0; m_resp = 0; m_rdata = 0;
         end else begin
            m_ack = dbg_req;
            if (grant) begin
               m_resp  = sw_lock ? 2'b01 : 2'b00;
               m_rdata = hlo ? m_cnt[31:0] : m_cnt[63:32];
            end else begin
               m_resp  = dbg_req ? 2'b11 : 2'b00;
               m_rdata = '0;
            end
         end
         m_cnt = nxt;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // compare against the reference away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk(tag, "count", count_o, m_cnt);
         chk(tag, "ovf", 64'(ovf_o), 64'(m_ovf));
         chk(tag, "ack/resp", {62'd0, dbg_ack, 1'b0} | 64'(dbg_resp) << 2,
             {62'd0, m_ack, 1'b0} | 64'(m_resp) << 2);
         chk(tag, "rdata", 64'(dbg_rdata), 64'(m_rdata));
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d);
      dbg_req = 1; dbg_wr = wr; dbg_addr = a; dbg_wdata = d;
      @(negedge clk);
      dbg_req = 0; dbg_wr = 0;
   endtask

   task automatic open_all();
      core_pwr = 1; dbl_lock = 0; os_lock = 0; ext_allow = 1; sw_lock = 0;
   endtask

   initial begin : watchdog
      #(20 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tag = "R1";
      idle(3);
      chk("R1", "reset count", count_o, 64'd0);
      rst_n = 1;
      idle(2);

      tag = "R2"; cnt_en = 1; div64_sel = 0;
      idle(30);

      tag = "R4";
      for (int i = 0; i < 60; i++) begin cnt_en = $urandom_range(0, 1); idle(1); end
      cnt_en = 0; idle(5);

      tag = "R3"; clr_pulse = 1; idle(1); clr_pulse = 0;
      div64_sel = 1; cnt_en = 1;
      idle(63);
      chk("R3", "no step before 64th", count_o, 64'd0);
      idle(1);
      chk("R3", "step on 64th", count_o, 64'd1);
      for (int i = 0; i < 300; i++) begin cnt_en = $urandom_range(0, 3) != 0; idle(1); end

      tag = "R5"; cnt_en = 1; idle(20);
      clr_pulse = 1; idle(1); clr_pulse = 0;
      chk("R5", "clear", count_o, 64'd0);
      idle(130);
      clr_pulse = 1; access(1, 12'h0FC, 32'hA5A5_0001); clr_pulse = 0;
      div64_sel = 0; idle(3);

      tag = "R7"; cnt_en = 0;
      access(1, 12'h0F8, 32'h1234_5678);
      access(0, 12'h0F8, 32'h0);
      chk("R7", "low word read", 64'(dbg_rdata), 64'h1234_5678);
      access(0, 12'h0FC, 32'h0);
      chk("R7", "high word read", 64'(dbg_rdata), 64'hA5A5_0001);
      cnt_en = 1; access(0, 12'h0F8, 0); access(0, 12'h0FC, 0); idle(2);

      tag = "R8"; cnt_en = 0;
      access(1, 12'h0F8, 32'hFFFF_FFFE);
      access(1, 12'h0FC, 32'h0000_0007);
      cnt_en = 1; idle(1);
      access(1, 12'h0F8, 32'h0000_0010);
      chk("R8", "write over carry", count_o, 64'h0000_0008_0000_0010);
      for (int i = 0; i < 40; i++) access(1, $urandom_range(0, 1) ? 12'h0FC : 12'h0F8, $urandom);

      tag = "R6";
      for (int i = 0; i < 200; i++) begin
         core_pwr = $urandom_range(0, 7) != 0; dbl_lock = $urandom_range(0, 7) == 0;
         os_lock = $urandom_range(0, 7) == 0; ext_allow = $urandom_range(0, 7) != 0;
         sw_lock = $urandom_range(0, 1); cnt_en = $urandom_range(0, 1);
         access($urandom_range(0, 1), $urandom_range(0, 3) == 0 ? 12'h100 :
                ($urandom_range(0, 1) ? 12'h0FC : 12'h0F8), $urandom);
      end
      open_all();

      tag = "R9"; cnt_en = 0;
      access(1, 12'h0F8, 32'h0000_00AA);
      sw_lock = 1; access(1, 12'h0F8, 32'hDEAD_BEEF);
      chk("R9", "locked write ignored", 64'(count_o[31:0]), 64'h0000_00AA);
      chk("R6", "read-only resp", 64'(dbg_resp), 64'd1);
      open_all(); os_lock = 1; access(1, 12'h0F8, 32'hDEAD_BEEF);
      chk("R9", "error write ignored", 64'(count_o[31:0]), 64'h0000_00AA);
      chk("R6", "error resp", 64'(dbg_resp), 64'd3);
      open_all(); access(1, 12'h0F4, 32'hDEAD_BEEF);
      chk("R6", "unmapped error", 64'(dbg_resp), 64'd3);
      open_all();

      tag = "R10";
      access(1, 12'h0FC, 32'hFFFF_FFFF);
      access(1, 12'h0F8, 32'hFFFF_FFF0);
      cnt_en = 1; idle(16);
      chk("R10", "wrapped", count_o, 64'd0);
      chk("R10", "flag", 64'(ovf_o), 64'd1);
      idle(1);
      chk("R10", "flag one cycle", 64'(ovf_o), 64'd0);
      cnt_en = 0;
      access(1, 12'h0FC, 32'hFFFF_FFFF);
      access(1, 12'h0F8, 32'hFFFF_FFFE);
      cnt_en = 1; idle(1);
      access(1, 12'h0F8, 32'h5);
      chk("R10", "no flag on write", 64'(ovf_o), 64'd0);
      idle(5);

      tag = "R11";
      dbg_req = 1; dbg_rst_n = 0; idle(6); dbg_req = 0;
      chk("R11", "port quiet", 64'(dbg_ack), 64'd0);
      dbg_rst_n = 1; idle(3);

      tag = "R1"; rst_n = 0; idle(2);
      chk("R1", "reset again", count_o, 64'd0);
      rst_n = 1; idle(2);

      tag = "R8";
      for (int i = 0; i < 1500; i++) begin
         cnt_en = $urandom_range(0, 3) != 0; div64_sel = $urandom_range(0, 3) == 0;
         clr_pulse = $urandom_range(0, 40) == 0; sw_lock = $urandom_range(0, 5) == 0;
         dbg_req = $urandom_range(0, 2) == 0; dbg_wr = $urandom_range(0, 1);
         dbg_addr = $urandom_range(0, 1) ? 12'h0FC : 12'h0F8; dbg_wdata = $urandom;
         idle(1);
      end
      dbg_req = 0; clr_pulse = 0; idle(2);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule